// File: doc/BRIEF.md
# System Clock Source Selector and Divider Chain

This block builds the main clock of a processor subsystem. It takes a crystal oscillator clock and a PLL output clock. It uses the PLL output only while the PLL is both enabled and reporting lock. In every other case it runs from the oscillator. The change between the two sources is glitch-free: the clock being left is shut off on its own low phase, and only then is the new clock let through.

The selected source drives a power-of-two system divider, which gives the intermediate system clock. A second divider then derives the subsystem clock from the system clock. Both dividers take a new ratio only when their own count wraps, so a ratio change never produces a short pulse.

An independent 10 MHz reference clock drives a missing-clock monitor for the oscillator. If the oscillator stops, the monitor sets a clock-fail flag, which is meant to be wired to the non-maskable interrupt request. The flag stays set until software clears it.

Top module: `sysclk_gen`

## Requirements
- R1: The selected source is the PLL clock when `pll_enable` and `pll_lock` are both 1. For any other combination it is the oscillator clock.
- R2: If `pll_lock` falls while the PLL is selected, the source returns to the oscillator without any other input changing. It goes back to the PLL once lock returns.
- R3: `sys_clk` is the source divided by 2^k. The code on `sys_div_sel` maps as follows: 0 gives /1, 1 gives /2, 2 gives /4, 3 gives /8, and 4 gives /16. The codes 5, 6 and 7 also give /16.
- R4: `sub_clk` is `sys_clk` divided by 2^`sub_div_sel`: 0 gives /1, 1 gives /2, 2 gives /4 and 3 gives /8.
- R5: A new divider ratio is taken only at the wrap of that divider's count. No high or low phase of `sys_clk` or `sub_clk` is ever shorter than half a PLL period.
- R6: The gates for the two sources are never open at the same time. Switching sources creates no phase shorter than half a PLL period.
- R7: `clk_fail` is set once the oscillator has shown no edge for 64 reference periods; the monitor sees the oscillator through a /32 prescaler. With the default parameters, the flag is still 0 at 58 reference periods after the oscillator stops and is 1 by 72. It never sets while the oscillator runs.
- R8: `clk_fail` is sticky. It stays 1 after the oscillator restarts, and it goes to 0 only when `fail_clear` is sampled high on a reference edge.
- R9: After reset, the oscillator is the source, both dividers run at the ratio on their select inputs, and `clk_fail` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled in every clock domain |
| osc_clk | input | 1 | Oscillator clock |
| pll_clk | input | 1 | PLL output clock |
| ref_clk | input | 1 | Independent 10 MHz reference for the missing-clock monitor |
| pll_enable | input | 1 | PLL enabled and requested as source |
| pll_lock | input | 1 | PLL lock indication |
| sys_div_sel | input | 3 | System divider code (R3) |
| sub_div_sel | input | 2 | Subsystem divider exponent (R4) |
| fail_clear | input | 1 | Clears the clock-fail flag (ref domain) |
| sys_clk | output | 1 | Intermediate system clock |
| sub_clk | output | 1 | Subsystem clock |
| clk_fail | output | 1 | Sticky oscillator-loss flag, non-maskable interrupt request |

## Verification
The bench sweeps both sources against all eight system codes and all four subsystem exponents, and it measures the periods of `sys_clk` and `sub_clk`. This separates a wrong source from a wrong ratio, because the 8 ns and 5 ns source periods never produce the same products. The codes 5 to 7 show whether saturation at /16 works. Separate runs toggle enable and lock on their own, so a design that ignores lock can be told apart from one that ignores enable. An edge-width monitor catches runt phases during every ratio change and every source change. Stopping and restarting the oscillator places the fail flag inside its timing window, and it also shows the flag is sticky and is cleared only by the clear input.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/100ps
package sysclk_pkg;

    typedef enum logic {
        SRC_OSC = 1'b0,
        SRC_PLL = 1'b1
    } src_sel_t;

    localparam int SYS_MAX_LOG2 = 4;
    localparam int SUB_MAX_LOG2 = 3;
    localparam int SYS_KW = $clog2(SYS_MAX_LOG2 + 1);
    localparam int SUB_KW = $clog2(SUB_MAX_LOG2 + 1);

    typedef struct packed {
        logic [SYS_KW-1:0] sys_k;
        logic [SUB_KW-1:0] sub_k;
    } div_cfg_t;

    function automatic logic [SYS_KW-1:0] sys_code_to_k(input logic [2:0] code);
        if (int'(code) > SYS_MAX_LOG2)
            return SYS_KW'(SYS_MAX_LOG2);
        return SYS_KW'(code);
    endfunction

endpackage

// File: rtl/sysclk_src_mux.sv
`timescale 1ns/100ps
module sysclk_src_mux #(
    parameter int SYNC_STAGES = 2
) (
    input  logic rst,
    input  logic clk_a,
    input  logic clk_b,
    input  logic pick_b,
    output logic clk_out,
    output logic en_a,
    output logic en_b
);
    logic [SYNC_STAGES-1:0] pick_in_a;
    logic [SYNC_STAGES-1:0] pick_in_b;
    logic [SYNC_STAGES-1:0] enb_in_a;
    logic [SYNC_STAGES-1:0] ena_in_b;

    always_ff @(posedge clk_a) begin
        if (rst) begin
            pick_in_a <= '0;
            enb_in_a  <= '0;
        end else begin
            pick_in_a <= {pick_in_a[SYNC_STAGES-2:0], pick_b};
            enb_in_a  <= {enb_in_a[SYNC_STAGES-2:0], en_b};
        end
    end

    always_ff @(negedge clk_a) begin
        if (rst) en_a <= 1'b1;
        else     en_a <= !pick_in_a[SYNC_STAGES-1] && !enb_in_a[SYNC_STAGES-1];
    end

    always_ff @(posedge clk_b) begin
        if (rst) begin
            pick_in_b <= '0;
            ena_in_b  <= '1;
        end else begin
            pick_in_b <= {pick_in_b[SYNC_STAGES-2:0], pick_b};
            ena_in_b  <= {ena_in_b[SYNC_STAGES-2:0], en_a};
        end
    end

    always_ff @(negedge clk_b) begin
        if (rst) en_b <= 1'b0;
        else     en_b <= pick_in_b[SYNC_STAGES-1] && !ena_in_b[SYNC_STAGES-1];
    end

    assign clk_out = (clk_a && en_a) || (clk_b && en_b);
endmodule

// File: rtl/sysclk_pow2_div.sv
`timescale 1ns/100ps
module sysclk_pow2_div #(
    parameter int MAX_LOG2 = 4,
    localparam int KW = $clog2(MAX_LOG2 + 1),
    localparam int CW = MAX_LOG2
) (
    input  logic          rst,
    input  logic          clk_in,
    input  logic [KW-1:0] k_new,
    output logic          clk_out,
    output logic          at_wrap,
    output logic [KW-1:0] k_cur
);
    logic [CW-1:0] cnt;
    logic [CW:0]   last;
    logic [CW:0]   half;
    logic [CW:0]   cnt_inc;
    logic          phase_hi;

    always_comb begin
        last    = ((CW+1)'(1) << k_cur) - (CW+1)'(1);
        half    = (k_cur == '0) ? '0 : ((CW+1)'(1) << (k_cur - KW'(1)));
        cnt_inc = {1'b0, cnt} + (CW+1)'(1);
        at_wrap = ({1'b0, cnt} == last);
    end

    always_ff @(posedge clk_in) begin
        if (rst) begin
            k_cur    <= '0;
            cnt      <= '0;
            phase_hi <= 1'b0;
        end else if (at_wrap) begin
            k_cur    <= k_new;
            cnt      <= '0;
            phase_hi <= (k_new != '0);
        end else begin
            cnt      <= cnt_inc[CW-1:0];
            phase_hi <= (cnt_inc < half);
        end
    end

    assign clk_out = (k_cur == '0) ? clk_in : phase_hi;
endmodule

// File: rtl/sysclk_osc_monitor.sv
`timescale 1ns/100ps
module sysclk_osc_monitor #(
    parameter int PRESCALE_W = 5,
    parameter int MISS_LIMIT = 64,
    localparam int MW = $clog2(MISS_LIMIT + 1)
) (
    input  logic rst,
    input  logic osc_clk,
    input  logic ref_clk,
    input  logic fail_clear,
    output logic osc_edge,
    output logic clk_fail
);
    logic [PRESCALE_W-1:0] pre_cnt;
    logic [2:0]            tap_sync;
    logic [MW-1:0]         miss_cnt;
    logic                  limit_hit;

    always_ff @(posedge osc_clk) begin
        if (rst) pre_cnt <= '0;
        else     pre_cnt <= pre_cnt + PRESCALE_W'(1);
    end

    always_ff @(posedge ref_clk) begin
        if (rst) tap_sync <= '0;
        else     tap_sync <= {tap_sync[1:0], pre_cnt[PRESCALE_W-1]};
    end

    assign osc_edge  = tap_sync[2] ^ tap_sync[1];
    assign limit_hit = (miss_cnt >= MW'(MISS_LIMIT - 1)) && !osc_edge;

    always_ff @(posedge ref_clk) begin
        if (rst || osc_edge)
            miss_cnt <= '0;
        else if (miss_cnt != MW'(MISS_LIMIT))
            miss_cnt <= miss_cnt + MW'(1);
    end

    always_ff @(posedge ref_clk) begin
        if (rst)             clk_fail <= 1'b0;
        else if (fail_clear) clk_fail <= 1'b0;
        else if (limit_hit)  clk_fail <= 1'b1;
    end
endmodule

// File: rtl/sysclk_gen.sv
`timescale 1ns/100ps
module sysclk_gen
    import sysclk_pkg::*;
#(
    parameter int PRESCALE_W = 5,
    parameter int MISS_LIMIT = 64
) (
    input  logic       rst,
    input  logic       osc_clk,
    input  logic       pll_clk,
    input  logic       ref_clk,
    input  logic       pll_enable,
    input  logic       pll_lock,
    input  logic [2:0] sys_div_sel,
    input  logic [1:0] sub_div_sel,
    input  logic       fail_clear,
    output logic       sys_clk,
    output logic       sub_clk,
    output logic       clk_fail
);
    src_sel_t          req_src;
    div_cfg_t          cfg;
    logic              src_clk;
    logic              osc_gate;
    logic              pll_gate;
    logic              sys_wrap;
    logic              sub_wrap;
    logic [SYS_KW-1:0] sys_k_cur;
    logic [SUB_KW-1:0] sub_k_cur;
    logic              osc_edge;

    assign req_src   = (pll_enable && pll_lock) ? SRC_PLL : SRC_OSC;
    assign cfg.sys_k = sys_code_to_k(sys_div_sel);
    assign cfg.sub_k = sub_div_sel;

    sysclk_src_mux #(.SYNC_STAGES(2)) u_mux (
        .rst     (rst),
        .clk_a   (osc_clk),
        .clk_b   (pll_clk),
        .pick_b  (req_src == SRC_PLL),
        .clk_out (src_clk),
        .en_a    (osc_gate),
        .en_b    (pll_gate)
    );

    sysclk_pow2_div #(.MAX_LOG2(SYS_MAX_LOG2)) u_sys_div (
        .rst     (rst),
        .clk_in  (src_clk),
        .k_new   (cfg.sys_k),
        .clk_out (sys_clk),
        .at_wrap (sys_wrap),
        .k_cur   (sys_k_cur)
    );

    sysclk_pow2_div #(.MAX_LOG2(SUB_MAX_LOG2)) u_sub_div (
        .rst     (rst),
        .clk_in  (sys_clk),
        .k_new   (cfg.sub_k),
        .clk_out (sub_clk),
        .at_wrap (sub_wrap),
        .k_cur   (sub_k_cur)
    );

    sysclk_osc_monitor #(
        .PRESCALE_W (PRESCALE_W),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_mon (
        .rst        (rst),
        .osc_clk    (osc_clk),
        .ref_clk    (ref_clk),
        .fail_clear (fail_clear),
        .osc_edge   (osc_edge),
        .clk_fail   (clk_fail)
    );
endmodule

// File: rtl/sysclk_gen_chk.sv
`timescale 1ns/100ps
module sysclk_gen_chk
    import sysclk_pkg::*;
(
    input logic              rst,
    input logic              pll_clk,
    input logic              ref_clk,
    input logic              src_clk,
    input logic              sys_clk,
    input logic              osc_gate,
    input logic              pll_gate,
    input logic              sys_wrap,
    input logic [SYS_KW-1:0] sys_k_cur,
    input logic              sub_wrap,
    input logic [SUB_KW-1:0] sub_k_cur,
    input logic              osc_edge,
    input logic              fail_clear,
    input logic              clk_fail
);
    assert_gates_exclusive_R6: assert property (@(posedge pll_clk) disable iff (rst)
        !(osc_gate && pll_gate));

    assert_sys_ratio_hold_R5: assert property (@(posedge src_clk) disable iff (rst)
        !sys_wrap |=> $stable(sys_k_cur));

    assert_sub_ratio_hold_R5: assert property (@(posedge sys_clk) disable iff (rst)
        !sub_wrap |=> $stable(sub_k_cur));

    assert_sys_ratio_range_R3: assert property (@(posedge src_clk) disable iff (rst)
        int'(sys_k_cur) <= SYS_MAX_LOG2);

    assert_fail_sticky_R8: assert property (@(posedge ref_clk) disable iff (rst)
        (clk_fail && !fail_clear) |=> clk_fail);

    assert_no_fail_after_edge_R7: assert property (@(posedge ref_clk) disable iff (rst)
        osc_edge |=> !$rose(clk_fail));
endmodule

bind sysclk_gen sysclk_gen_chk u_chk (
    .rst        (rst),
    .pll_clk    (pll_clk),
    .ref_clk    (ref_clk),
    .src_clk    (src_clk),
    .sys_clk    (sys_clk),
    .osc_gate   (osc_gate),
    .pll_gate   (pll_gate),
    .sys_wrap   (sys_wrap),
    .sys_k_cur  (sys_k_cur),
    .sub_wrap   (sub_wrap),
    .sub_k_cur  (sub_k_cur),
    .osc_edge   (osc_edge),
    .fail_clear (fail_clear),
    .clk_fail   (clk_fail)
);

// File: tb/sysclk_gen_tb.sv
`timescale 1ns/100ps
module sysclk_gen_tb;
    localparam realtime OSC_P = 8.0;
    localparam realtime PLL_P = 5.0;
    localparam realtime REF_P = 100.0;
    localparam realtime RUNT  = 2.4;

    logic       rst = 1'b1;
    logic       osc_clk = 1'b0;
    logic       pll_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       osc_run = 1'b1;
    logic       pll_enable = 1'b0;
    logic       pll_lock = 1'b0;
    logic [2:0] sys_div_sel = 3'd0;
    logic [1:0] sub_div_sel = 2'd0;
    logic       fail_clear = 1'b0;
    logic       sys_clk;
    logic       sub_clk;
    logic       clk_fail;

    int checks = 0;
    int errors = 0;
    int runts  = 0;
    bit mon_on = 1'b0;
    realtime last_sys = 0.0;
    realtime last_sub = 0.0;

    always begin
        #(OSC_P/2);
        if (osc_run) osc_clk = ~osc_clk;
        else         osc_clk = 1'b0;
    end
    always #(PLL_P/2) pll_clk = ~pll_clk;
    always #(REF_P/2) ref_clk = ~ref_clk;

    sysclk_gen u_dut (
        .rst         (rst),
        .osc_clk     (osc_clk),
        .pll_clk     (pll_clk),
        .ref_clk     (ref_clk),
        .pll_enable  (pll_enable),
        .pll_lock    (pll_lock),
        .sys_div_sel (sys_div_sel),
        .sub_div_sel (sub_div_sel),
        .fail_clear  (fail_clear),
        .sys_clk     (sys_clk),
        .sub_clk     (sub_clk),
        .clk_fail    (clk_fail)
    );

    always @(sys_clk) begin
        if (mon_on && ($realtime - last_sys) < RUNT) runts++;
        last_sys = $realtime;
    end
    always @(sub_clk) begin
        if (mon_on && ($realtime - last_sub) < RUNT) runts++;
        last_sub = $realtime;
    end

    task automatic check_time(input string req, input realtime act, input realtime exp);
        checks++;
        if (act < exp - 0.05 || act > exp + 0.05) begin
            errors++;
            $display("FAIL %s: period %0.1f expected %0.1f", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: value %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic sys_period(output realtime p);
        realtime t0;
        @(posedge sys_clk);
        t0 = $realtime;
        @(posedge sys_clk);
        p = $realtime - t0;
    endtask

    task automatic sub_period(output realtime p);
        realtime t0;
        @(posedge sub_clk);
        t0 = $realtime;
        @(posedge sub_clk);
        p = $realtime - t0;
    endtask

    function automatic int sys_ratio(input int code);
        return 1 << ((code > 4) ? 4 : code);
    endfunction

    task automatic finish_run;
        checks++;
        if (runts != 0) begin
            errors++;
            $display("FAIL R5 R6: runt phases %0d expected 0", runts);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(OSC_P * 190000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        realtime p;
        realtime src_p;
        #(REF_P * 12);
        @(negedge osc_clk);
        rst = 1'b0;
        #200;
        mon_on = 1'b1;

        // R9: reset state runs from the oscillator at /1, flag clear
        sys_period(p);
        check_time("R9 reset source", p, OSC_P);
        check_bit("R9 reset flag", clk_fail, 1'b0);

        // R1: enable alone and lock alone keep the oscillator
        pll_enable = 1'b1; pll_lock = 1'b0; #300;
        sys_period(p);
        check_time("R1 enable without lock", p, OSC_P);
        pll_enable = 1'b0; pll_lock = 1'b1; #300;
        sys_period(p);
        check_time("R1 lock without enable", p, OSC_P);
        pll_enable = 1'b1; #300;
        sys_period(p);
        check_time("R1 enable and lock", p, PLL_P);

        // R2: lock loss falls back, relock returns
        pll_lock = 1'b0; #300;
        sys_period(p);
        check_time("R2 fallback on lock loss", p, OSC_P);
        pll_lock = 1'b1; #300;
        sys_period(p);
        check_time("R2 return on relock", p, PLL_P);

        // R3, R4: sweep of source, system code and subsystem exponent
        for (int s = 0; s < 2; s++) begin
            pll_enable = (s == 1);
            pll_lock   = 1'b1;
            src_p = (s == 1) ? PLL_P : OSC_P;
            for (int c = 0; c < 8; c++) begin
                for (int k = 0; k < 4; k++) begin
                    sys_div_sel = 3'(c);
                    sub_div_sel = 2'(k);
                    #(2.0 * src_p * sys_ratio(c) * (1 << k) + 300.0);
                    sys_period(p);
                    check_time($sformatf("R3 src%0d code%0d", s, c), p,
                               src_p * sys_ratio(c));
                    sub_period(p);
                    check_time($sformatf("R4 src%0d code%0d exp%0d", s, c, k), p,
                               src_p * sys_ratio(c) * (1 << k));
                end
            end
        end

        // R7, R8: oscillator loss on the oscillator path
        pll_enable = 1'b0;
        sys_div_sel = 3'd0;
        sub_div_sel = 2'd0;
        #2000;
        repeat (80) @(negedge ref_clk);
        check_bit("R7 no fail while running", clk_fail, 1'b0);
        osc_run = 1'b0;
        repeat (58) @(negedge ref_clk);
        check_bit("R7 not yet failed", clk_fail, 1'b0);
        repeat (14) @(negedge ref_clk);
        check_bit("R7 failed", clk_fail, 1'b1);
        osc_run = 1'b1;
        repeat (20) @(negedge ref_clk);
        check_bit("R8 sticky after restart", clk_fail, 1'b1);
        fail_clear = 1'b1;
        @(negedge ref_clk);
        fail_clear = 1'b0;
        @(negedge ref_clk);
        check_bit("R8 cleared", clk_fail, 1'b0);
        repeat (80) @(negedge ref_clk);
        check_bit("R7 stays clear with oscillator", clk_fail, 1'b0);
        sys_period(p);
        check_time("R1 oscillator back", p, OSC_P);

        // R5, R6: no runt phases during any change above
        finish_run();
    end
endmodule